// File: doc/BRIEF.md
# HDLC Serial Receive Deframer

This block turns a bit-serial HDLC line into a byte stream. Every cycle in which `bit_valid` is high it takes one line bit. It hunts bit by bit for the flag pattern, removes the zeros a transmitter inserts after runs of five ones, and packs the remaining bits into bytes, least significant bit first. The two bytes just before each closing flag are the frame check sequence. They are held back, checked against the CRC residue and never passed on.

Each frame is reported as a run of `byte_valid` pulses, with the first one marked by `byte_first`. A single `frame_end` pulse follows, carrying a two-bit status. A run of seven or more ones on the line is an abort: it always pulses `abort_seen`, and it pulses `frame_abort` as well when it cuts off a frame that had already collected enough bytes to be valid. An optional address filter drops whole frames whose first byte does not match the configured receive address.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: A 0 followed by six 1s and then a 0 (a flag) puts the receiver into a frame. No flag bit ever reaches `byte_data`. Back-to-back flags with no byte between them produce no output at all.
- R2: Inside a frame, a 0 that directly follows five consecutive 1s is removed before bytes are assembled.
- R3: Bytes are assembled LSB first. The last two bytes before the closing flag are withheld. Each other byte appears as a one-cycle `byte_valid` pulse, and `byte_first` is high only on the first byte of a frame. Outputs are registered and appear one cycle after the line bit that causes them.
- R4: The CRC register is preset to all ones at each flag and runs over every data and check bit. At the closing flag, a remainder of 0xF0B8 gives status 0 (good). Any other remainder gives status 1 (bad).
- R5: `frame_end` pulses once per closed frame that holds at least one byte, with `frame_status` valid in the same cycle. A frame of fewer than four bytes (check bytes included) reports status 3 (short).
- R6: A frame of four or more bytes that closes with a partial byte reports status 1.
- R7: Seven consecutive 1s pulse `abort_seen` once per run of ones, whether or not a frame is open. Inside a frame, the abort discards the frame, reports `frame_end` with status 2 if at least one byte was received, and returns the receiver to flag hunting.
- R8: `frame_abort` pulses together with `abort_seen` only when the abort follows an opening flag and at least four received bytes.
- R9: When `addr_filt_en` is high, a frame is passed only if its first byte equals `rx_addr` in bits 7..1, or is 0xFF. Bit 0 of both bytes is ignored. A rejected frame produces no `byte_valid` and no `frame_end`.
- R10: With `addr_filt_en` and `addr_six_mode` both high, only bits 7..2 are compared.
- R11: One flag can close a frame and open the next.
- R12: Cycles with `bit_valid` low are ignored whatever `bit_in` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | `bit_in` carries a line bit this cycle |
| bit_in | input | 1 | Serial line bit |
| addr_filt_en | input | 1 | Enable the address filter |
| addr_six_mode | input | 1 | Compare only address bits 7..2 |
| rx_addr | input | 8 | Receive address (bit 0 unused) |
| byte_valid | output | 1 | `byte_data` holds a frame byte |
| byte_data | output | 8 | Frame byte |
| byte_first | output | 1 | First byte of a frame |
| frame_end | output | 1 | End-of-frame report |
| frame_status | output | 2 | 0 good, 1 bad, 2 aborted, 3 short |
| abort_seen | output | 1 | Seven-ones abort detected |
| frame_abort | output | 1 | Abort that ended a frame of at least four bytes |

## Verification
The assertions check the cycle-level rules on every clock. At most one line event (push, stuff, flag, abort) can occur per bit. No byte is produced while hunting, and every output pulse is traced back to an accepted line bit. `byte_first` comes with `byte_valid`, end reports never overlap a byte, and frame aborts and abort statuses coincide with `abort_seen`. Some behaviours need whole bit streams and are shown only by the bench scenarios: byte values and order, the withholding of the check bytes, CRC residue results, short and partial frames, address acceptance in both compare widths, and shared flags.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [CRC_W-1:0]  crc_t;

  typedef enum logic [1:0] {
    END_GOOD  = 2'd0,
    END_BAD   = 2'd1,
    END_ABORT = 2'd2,
    END_SHORT = 2'd3
  } end_status_e;

  // One LSB-first step of a reflected CRC register.
  function automatic crc_t crc_step(input crc_t cur, input logic din, input crc_t poly_rev);
    logic fb;
    crc_t nxt;
    fb  = cur[0] ^ din;
    nxt = cur >> 1;
    if (fb) nxt = nxt ^ poly_rev;
    return nxt;
  endfunction

  // Address acceptance: broadcast, or match on upper seven (or six) bits.
  function automatic logic addr_accept(input byte_t rx, input byte_t stored,
                                       input logic en, input logic six);
    byte_t keep;
    keep = six ? byte_t'(8'hFC) : byte_t'(8'hFE);
    return !en || (&rx) || ((rx & keep) == (stored & keep));
  endfunction

  // Closing-flag status, short frames taking precedence.
  function automatic end_status_e close_status(input logic long_enough, input logic partial,
                                               input logic crc_ok);
    if (!long_enough)        return END_SHORT;
    if (partial || !crc_ok)  return END_BAD;
    return END_GOOD;
  endfunction

endpackage

// File: rtl/hdlc_rx_linecode.sv
module hdlc_rx_linecode #(
  parameter int STUFF_RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_in,
  output logic ev_push,
  output logic ev_stuff,
  output logic ev_flag,
  output logic ev_abort
);
  localparam int FLAG_RUN  = STUFF_RUN + 1;
  localparam int ABORT_RUN = STUFF_RUN + 2;
  localparam int RUN_W     = $clog2(ABORT_RUN + 1);

  logic [RUN_W-1:0] run_q;

  always_comb begin
    ev_push  = 1'b0;
    ev_stuff = 1'b0;
    ev_flag  = 1'b0;
    ev_abort = 1'b0;
    if (bit_valid) begin
      if (bit_in) begin
        if (run_q < RUN_W'(STUFF_RUN))       ev_push  = 1'b1;
        else if (run_q == RUN_W'(FLAG_RUN))  ev_abort = 1'b1;
      end else begin
        if (run_q == RUN_W'(FLAG_RUN))       ev_flag  = 1'b1;
        else if (run_q == RUN_W'(STUFF_RUN)) ev_stuff = 1'b1;
        else if (run_q < RUN_W'(STUFF_RUN))  ev_push  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (bit_valid) begin
      if (!bit_in)                              run_q <= '0;
      else if (run_q != RUN_W'(ABORT_RUN))      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_rx_guard.sv
// Holds the newest DEPTH destuffed bits so the head of a closing flag
// never reaches the byte packer.
module hdlc_rx_guard #(
  parameter int DEPTH = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic in_vld,
  input  logic in_bit,
  output logic out_vld,
  output logic out_bit
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] line_q;
  logic [CW-1:0]    fill_q;
  logic             full;

  assign full    = (fill_q == CW'(DEPTH));
  assign out_vld = in_vld && full;
  assign out_bit = line_q[DEPTH-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
      fill_q <= '0;
    end else if (clear) begin
      fill_q <= '0;
    end else if (in_vld) begin
      line_q <= {line_q[DEPTH-2:0], in_bit};
      if (!full) fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_rx_bytepack.sv
module hdlc_rx_bytepack
  import hdlc_rx_pkg::*;
#(
  parameter crc_t POLY_REV = 16'h8408,
  parameter crc_t INIT     = 16'hFFFF
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  in_vld,
  input  logic  in_bit,
  output logic  byte_done,
  output byte_t byte_val,
  output logic  partial,
  output crc_t  crc_q
);
  localparam int CNT_W = $clog2(BYTE_W);

  byte_t             shift_q;
  logic [CNT_W-1:0]  cnt_q;

  assign byte_val  = {in_bit, shift_q[BYTE_W-1:1]};
  assign byte_done = in_vld && (cnt_q == CNT_W'(BYTE_W - 1));
  assign partial   = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
      crc_q   <= INIT;
    end else if (clear) begin
      cnt_q   <= '0;
      crc_q   <= INIT;
    end else if (in_vld) begin
      shift_q <= byte_val;
      cnt_q   <= byte_done ? '0 : cnt_q + 1'b1;
      crc_q   <= crc_step(crc_q, in_bit, POLY_REV);
    end
  end
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int   FCS_BYTES    = 2,
  parameter int   MIN_BYTES    = 4,
  parameter int   STUFF_RUN    = 5,
  parameter crc_t CRC_POLY_REV = 16'h8408,
  parameter crc_t CRC_INIT     = 16'hFFFF,
  parameter crc_t CRC_RESIDUE  = 16'hF0B8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_valid,
  input  logic       bit_in,
  input  logic       addr_filt_en,
  input  logic       addr_six_mode,
  input  logic [7:0] rx_addr,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       byte_first,
  output logic       frame_end,
  output logic [1:0] frame_status,
  output logic       abort_seen,
  output logic       frame_abort
);
  localparam int NB_W        = $clog2(MIN_BYTES + 1);
  localparam int HELD_W      = $clog2(FCS_BYTES + 1);
  localparam int GUARD_DEPTH = STUFF_RUN + 1;

  // line events
  logic ev_push, ev_stuff, ev_flag, ev_abort;
  // guard / packer
  logic  g_vld, g_bit;
  logic  byte_done, partial;
  byte_t byte_val;
  crc_t  crc_q;
  // framing state
  logic              in_frame_q;
  logic [NB_W-1:0]   nbytes_q;
  logic [HELD_W-1:0] held_q;
  logic              accept_q;
  logic              sof_pend_q;
  byte_t             hold_q [FCS_BYTES];
  // decoded events
  logic        frame_reset, has_bytes, enough, addr_hit;
  logic        emit, close_rpt, abort_rpt, fa_evt;
  end_status_e close_st;

  hdlc_rx_linecode #(.STUFF_RUN(STUFF_RUN)) u_line (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .ev_push(ev_push), .ev_stuff(ev_stuff), .ev_flag(ev_flag), .ev_abort(ev_abort)
  );

  assign frame_reset = ev_flag || ev_abort;

  hdlc_rx_guard #(.DEPTH(GUARD_DEPTH)) u_guard (
    .clk(clk), .rst_n(rst_n), .clear(frame_reset),
    .in_vld(ev_push && in_frame_q), .in_bit(bit_in),
    .out_vld(g_vld), .out_bit(g_bit)
  );

  hdlc_rx_bytepack #(.POLY_REV(CRC_POLY_REV), .INIT(CRC_INIT)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear(frame_reset),
    .in_vld(g_vld), .in_bit(g_bit),
    .byte_done(byte_done), .byte_val(byte_val), .partial(partial), .crc_q(crc_q)
  );

  assign has_bytes = (nbytes_q != '0);
  assign enough    = (nbytes_q >= NB_W'(MIN_BYTES));
  assign addr_hit  = addr_accept(byte_val, rx_addr, addr_filt_en, addr_six_mode);
  assign emit      = byte_done && (held_q == HELD_W'(FCS_BYTES)) && accept_q;
  assign close_rpt = ev_flag && in_frame_q && has_bytes && accept_q;
  assign abort_rpt = ev_abort && in_frame_q && has_bytes && accept_q;
  assign fa_evt    = ev_abort && in_frame_q && enough;
  assign close_st  = close_status(enough, partial, crc_q == CRC_RESIDUE);

  // outputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_valid   <= 1'b0;
      byte_data    <= '0;
      byte_first   <= 1'b0;
      frame_end    <= 1'b0;
      frame_status <= '0;
      abort_seen   <= 1'b0;
      frame_abort  <= 1'b0;
    end else begin
      byte_valid  <= emit;
      byte_first  <= emit && sof_pend_q;
      if (emit) byte_data <= hold_q[FCS_BYTES-1];
      frame_end   <= close_rpt || abort_rpt;
      if (abort_rpt)      frame_status <= END_ABORT;
      else if (close_rpt) frame_status <= close_st;
      abort_seen  <= ev_abort;
      frame_abort <= fa_evt;
    end
  end

  // frame bookkeeping
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      nbytes_q   <= '0;
      held_q     <= '0;
      accept_q   <= 1'b0;
      sof_pend_q <= 1'b0;
      for (int i = 0; i < FCS_BYTES; i++) hold_q[i] <= '0;
    end else if (frame_reset) begin
      in_frame_q <= ev_flag;
      nbytes_q   <= '0;
      held_q     <= '0;
      accept_q   <= 1'b0;
      sof_pend_q <= 1'b1;
    end else if (byte_done) begin
      if (!enough)                           nbytes_q <= nbytes_q + 1'b1;
      if (held_q != HELD_W'(FCS_BYTES))      held_q   <= held_q + 1'b1;
      if (!has_bytes)                        accept_q <= addr_hit;
      if (emit)                              sof_pend_q <= 1'b0;
      hold_q[0] <= byte_val;
      for (int i = 1; i < FCS_BYTES; i++) hold_q[i] <= hold_q[i-1];
    end
  end
endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_valid,
  input logic       ev_push,
  input logic       ev_stuff,
  input logic       ev_flag,
  input logic       ev_abort,
  input logic       in_frame,
  input logic       byte_valid,
  input logic       byte_first,
  input logic       frame_end,
  input logic [1:0] frame_status,
  input logic       abort_seen,
  input logic       frame_abort
);
  a_r1_one_line_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_push, ev_stuff, ev_flag, ev_abort}));

  a_r1_no_byte_while_hunting: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(in_frame));

  a_r3_first_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
    byte_first |-> byte_valid);

  a_r5_end_apart_from_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_end && byte_valid));

  a_r7_abort_leaves_frame: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> !in_frame);

  a_r7_abort_status_coincides: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && frame_status == 2'd2) |-> abort_seen);

  a_r8_frame_abort_coincides: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |-> abort_seen);

  a_r12_outputs_follow_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid || frame_end || abort_seen) |-> $past(bit_valid));
endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid),
  .ev_push(ev_push), .ev_stuff(ev_stuff), .ev_flag(ev_flag), .ev_abort(ev_abort),
  .in_frame(in_frame_q),
  .byte_valid(byte_valid), .byte_first(byte_first), .frame_end(frame_end),
  .frame_status(frame_status), .abort_seen(abort_seen), .frame_abort(frame_abort)
);

// File: tb/hdlc_rx_deframer_tb.sv
module hdlc_rx_deframer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_valid = 1'b0;
  logic       bit_in = 1'b0;
  logic       addr_filt_en = 1'b0;
  logic       addr_six_mode = 1'b0;
  logic [7:0] rx_addr = 8'h00;
  logic       byte_valid, byte_first, frame_end, abort_seen, frame_abort;
  logic [7:0] byte_data;
  logic [1:0] frame_status;

  always #10 clk = ~clk;  // 50 MHz

  hdlc_rx_deframer u_dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .addr_filt_en(addr_filt_en), .addr_six_mode(addr_six_mode), .rx_addr(rx_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_first(byte_first),
    .frame_end(frame_end), .frame_status(frame_status),
    .abort_seen(abort_seen), .frame_abort(frame_abort)
  );

  int checks = 0, fails = 0;
  int exp_ab = 0, exp_fa = 0, obs_ab = 0, obs_fa = 0;
  int q_evt[$];
  logic [7:0] pl[$];
  string cur_req = "R1";
  int run = 0, gap_ctr = 0, cyc = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      finish_run();
    end
  end

  // Stream monitor: every output event is compared against the expected queue.
  always @(negedge clk) if (rst_n) begin
    if (byte_valid) begin
      int act, e;
      act = (1 << 16) | (int'(byte_first) << 8) | int'(byte_data);
      e = (q_evt.size() > 0) ? q_evt.pop_front() : -1;
      check(act == e, cur_req, "byte event", act, e);
    end
    if (frame_end) begin
      int act, e;
      act = (2 << 16) | int'(frame_status);
      e = (q_evt.size() > 0) ? q_evt.pop_front() : -1;
      check(act == e, cur_req, "end event", act, e);
    end
    if (abort_seen)  obs_ab++;
    if (frame_abort) obs_fa++;
  end

  // Line driver; R12: idle gaps present the inverted bit with bit_valid low.
  task automatic send_bit(input bit b);
    @(negedge clk);
    gap_ctr++;
    if (gap_ctr % 7 == 0) begin
      bit_valid = 1'b0;
      bit_in    = ~b;
      @(negedge clk);
    end
    bit_valid = 1'b1;
    bit_in    = b;
  endtask

  task automatic send_flag();
    send_bit(0);
    repeat (6) send_bit(1);
    send_bit(0);
    run = 0;
  endtask

  task automatic send_stuffed(input bit b);
    send_bit(b);
    if (b) run++; else run = 0;
    if (run == 5) begin
      send_bit(0);
      run = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_stuffed(v[i]);
  endtask

  // MSB-first CRC over bit-reversed input, reflected and inverted at the end.
  function automatic logic [15:0] fcs_of();
    logic [15:0] c, r;
    bit fb;
    c = 16'hFFFF;
    foreach (pl[k]) begin
      for (int i = 0; i < 8; i++) begin
        fb = c[15] ^ pl[k][i];
        c  = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    end
    for (int i = 0; i < 16; i++) r[i] = c[15-i];
    return ~r;
  endfunction

  function automatic bit exp_accept(input logic [7:0] a);
    if (!addr_filt_en) return 1;
    if (a == 8'hFF) return 1;
    if (addr_six_mode) return (a >> 2) == (rx_addr >> 2);
    return (a >> 1) == (rx_addr >> 1);
  endfunction

  task automatic send_frame(input bit corrupt, input int extra);
    logic [15:0] f;
    logic [7:0] tx[$];
    int tot, st;
    f  = fcs_of();
    tx = pl;
    if (corrupt && tx.size() > 0) tx[tx.size()-1] = tx[tx.size()-1] ^ 8'h10;
    tot = tx.size() + 2;
    if (exp_accept(tx.size() > 0 ? tx[0] : f[7:0])) begin
      foreach (tx[i]) q_evt.push_back((1 << 16) | ((i == 0) << 8) | int'(tx[i]));
      st = (tot < 4) ? 3 : ((corrupt || extra > 0) ? 1 : 0);
      q_evt.push_back((2 << 16) | st);
    end
    foreach (tx[i]) send_byte(tx[i]);
    send_byte(f[7:0]);
    send_byte(f[15:8]);
    repeat (extra) send_stuffed(0);
    send_flag();
  endtask

  task automatic send_abort_frame();
    int n;
    n = pl.size();
    if (n > 0 && exp_accept(pl[0])) begin
      for (int i = 0; i + 2 < n; i++) q_evt.push_back((1 << 16) | ((i == 0) << 8) | int'(pl[i]));
      q_evt.push_back((2 << 16) | 2);
    end
    exp_ab++;
    if (n >= 4) exp_fa++;
    foreach (pl[i]) send_byte(pl[i]);
    send_bit(0);
    repeat (8) send_bit(1);
    run = 0;
    send_flag();
  endtask

  task automatic checkpoint(input string req);
    @(negedge clk);
    bit_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(q_evt.size() == 0, req, "pending expected events", q_evt.size(), 0);
    check(obs_ab == exp_ab, req, "abort_seen count", obs_ab, exp_ab);
    check(obs_fa == exp_fa, req, "frame_abort count", obs_fa, exp_fa);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({byte_valid, byte_first, frame_end, abort_seen, frame_abort} == 5'b0, "R1", "reset outputs",
          {byte_valid, byte_first, frame_end, abort_seen, frame_abort}, 0);

    cur_req = "R7";   // abort while hunting
    repeat (10) send_bit(1);
    exp_ab++;
    checkpoint("R7");

    cur_req = "R1";   // idle flags only
    repeat (3) send_flag();
    checkpoint("R1");

    cur_req = "R4";
    pl = {8'h42, 8'h11, 8'h22, 8'h33};
    send_frame(0, 0);
    checkpoint("R4");

    cur_req = "R2";   // heavy stuffing, frames share flags (R11)
    pl = {8'hFF, 8'h7E, 8'hFC, 8'h3F, 8'hFF};
    send_frame(0, 0);
    pl = {8'h5A, 8'hF8};
    send_frame(0, 0);
    checkpoint("R2 R11 R12");

    cur_req = "R4";
    pl = {8'h10, 8'h20, 8'h30};
    send_frame(1, 0);
    checkpoint("R4");

    cur_req = "R5";
    pl = {8'hA5};
    send_frame(0, 0);
    pl = {};
    send_frame(0, 0);
    checkpoint("R5");

    cur_req = "R6";
    pl = {8'h01, 8'h02, 8'h03};
    send_frame(0, 3);
    checkpoint("R6");

    cur_req = "R8";
    pl = {8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
    send_abort_frame();
    checkpoint("R8");
    cur_req = "R7";
    pl = {8'h09, 8'h08};
    send_abort_frame();
    checkpoint("R7");

    cur_req = "R9";
    addr_filt_en = 1'b1;
    rx_addr = 8'h43;
    pl = {8'h42, 8'hAA, 8'hBB}; send_frame(0, 0);
    pl = {8'h43, 8'hCC};        send_frame(0, 0);
    pl = {8'h44, 8'hDD, 8'hEE}; send_frame(0, 0);
    pl = {8'hFF, 8'h12};        send_frame(0, 0);
    pl = {8'h40, 8'h34};        send_frame(0, 0);
    checkpoint("R9");

    cur_req = "R10";
    addr_six_mode = 1'b1;
    pl = {8'h40, 8'h56, 8'h78}; send_frame(0, 0);
    pl = {8'h47, 8'h9A};        send_frame(0, 0);
    pl = {8'h48, 8'hBC};        send_frame(0, 0);
    checkpoint("R10");

    cur_req = "R3";
    addr_filt_en = 1'b0;
    addr_six_mode = 1'b0;
    pl = {8'h81, 8'h00, 8'hFE, 8'h7F, 8'h01, 8'h80};
    send_frame(0, 0);
    checkpoint("R3");

    finish_run();
  end
endmodule